// File: doc/BRIEF.md
# Arithmetic Circuit Evaluation Engine

This block checks that an arithmetic circuit, laid out in memory by the caller, evaluates to zero. A start command carries five values: a context, a clock tag, a word-aligned pointer, the number of variables to load and the number of instructions to execute. The engine gives every node of the circuit a descending identifier. The first node is numbered n_read + n_eval − 1 and the last one is 0.

The engine works in two phases. In the load phase it fetches whole memory words, each holding two field-extension values, and stores them as two consecutive nodes. Once the variables are used up it moves to the execute phase. There it fetches one packed instruction per step, applies subtract, multiply or add to two nodes already produced, and stores the result under the next identifier. The run ends when node 0 has been computed. That node must be zero for the evaluation to pass. Values are pairs over a prime field P, extended by a square root of a fixed non-residue NR.

Top module: `arith_circuit_engine`

## Requirements
- R1: After reset, busy, done, pass, err and rd_valid are all 0.
- R2: After an accepted start, the first memory request is a word read (rd_word = 1) at cmd_ptr. rd_ctx and rd_tag carry the command's context and tag, and stay constant for the whole evaluation.
- R3: A word read places slot k in bits [16k+FW-1:16k]. Slots 0 and 1 are the low and high limbs of node id. Slots 2 and 3 are the low and high limbs of node id−1. The next request address is 4 higher and the identifier drops by 2.
- R4: When the next identifier would equal n_eval − 1, requests switch to element reads (rd_word = 0). They never return to word reads within the same evaluation.
- R5: Each element read is at the previous address plus 1, and the identifier drops by 1.
- R6: An instruction element holds the left id in bits [29:0], the right id in bits [59:30] and a code in bits [61:60]. Code 0 is left − right, 1 is the product, 2 is left + right. Add and subtract work limb by limb mod P. The product is (a0·b0 + NR·a1·b1, a0·b1 + a1·b0) mod P.
- R7: done pulses for one cycle, in the cycle after the handshake that produces node 0. pass = 1 exactly when that node is (0,0), with err = 0. pass and err hold until the next accepted start.
- R8: Code 3 ends the evaluation at that instruction with done, err = 1 and pass = 0. No further request is made.
- R9: An operand id that is not above the current identifier, or not below n_read + n_eval, ends the evaluation in the same way as R8.
- R10: A start whose n_read is odd or zero, whose n_eval is zero, or whose total exceeds MAX_NODES gives done with err = 1 in the next cycle and makes no memory request.
- R11: A start while busy is ignored. The running evaluation's requests and result are unchanged.
- R12: While rd_valid is high and rd_ready is low, the request holds: rd_valid, rd_addr and rd_word are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken only when idle |
| cmd_ctx | input | CTX_W | Memory context for the evaluation |
| cmd_tag | input | TAG_W | Clock tag for the evaluation |
| cmd_ptr | input | ADDR_W | Word-aligned start address |
| cmd_nread | input | CNT_W | Number of variables to load |
| cmd_neval | input | CNT_W | Number of instructions to execute |
| busy | output | 1 | Evaluation in progress |
| rd_valid | output | 1 | Memory request valid |
| rd_ready | input | 1 | Memory request accepted, data present this cycle |
| rd_word | output | 1 | 1: word read, 0: element read |
| rd_addr | output | ADDR_W | Request address |
| rd_ctx | output | CTX_W | Request context |
| rd_tag | output | TAG_W | Request clock tag |
| rd_data | input | 64 | Read data, valid with the handshake |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Root node was zero |
| err | output | 1 | Malformed instruction or command |

## Verification
Every memory handshake takes one cycle. An unstalled evaluation with W words and E executed instructions therefore raises done in the cycle after the last of its W + E handshakes, or after the handshake of the faulting instruction. A rejected command raises done in the cycle after its start. The bench samples at falling edges and counts those edges from the start strobe, and without stalls it requires done exactly at handshakes + 1. Every handshake is compared against the address, width select, context and tag that the bench derives from the command. With stalls, only the order and count of the handshakes are checked.

// File: rtl/circ_eval_pkg.sv
package circ_eval_pkg;
   localparam int OPND_W    = 30;
   localparam int RIGHT_LSB = 30;
   localparam int CODE_LSB  = 60;
   localparam int SLOT_W    = 16;
   localparam int MEM_W     = 64;

   typedef enum logic [1:0] {
      OP_SUB  = 2'd0,
      OP_MUL  = 2'd1,
      OP_ADD  = 2'd2,
      OP_RSVD = 2'd3
   } op_code_e;

   typedef enum logic {
      PH_LOAD = 1'b0,
      PH_EXEC = 1'b1
   } phase_e;
endpackage

// File: rtl/circ_ext_alu.sv
module circ_ext_alu
   import circ_eval_pkg::*;
#(
   parameter int P  = 97,
   parameter int FW = 7,
   parameter int NR = 7
) (
   input  op_code_e       op,
   input  logic [FW-1:0]  a0,
   input  logic [FW-1:0]  a1,
   input  logic [FW-1:0]  b0,
   input  logic [FW-1:0]  b1,
   output logic [FW-1:0]  r0,
   output logic [FW-1:0]  r1
);
   localparam int PW = 2 * FW + 9;
   localparam int SW = FW + 1;

   generate
      if (P >= (1 << FW)) begin : g_bad_modulus
         $error("modulus does not fit the limb width");
      end
      if (NR >= P || NR > 255) begin : g_bad_nonresidue
         $error("non-residue out of range");
      end
   endgenerate

   logic [SW-1:0] sum0, sum1, dif0, dif1;
   logic [PW-1:0] prod0, prod1;

   always_comb begin
      sum0  = SW'(a0) + SW'(b0);
      sum1  = SW'(a1) + SW'(b1);
      dif0  = SW'(a0) + SW'(P) - SW'(b0);
      dif1  = SW'(a1) + SW'(P) - SW'(b1);
      prod0 = (PW'(a0) * PW'(b0) + PW'(NR) * PW'(a1) * PW'(b1)) % PW'(P);
      prod1 = (PW'(a0) * PW'(b1) + PW'(a1) * PW'(b0)) % PW'(P);
      unique case (op)
         OP_SUB: begin
            r0 = FW'(dif0 % SW'(P));
            r1 = FW'(dif1 % SW'(P));
         end
         OP_MUL: begin
            r0 = FW'(prod0);
            r1 = FW'(prod1);
         end
         OP_ADD: begin
            r0 = FW'(sum0 % SW'(P));
            r1 = FW'(sum1 % SW'(P));
         end
         default: begin
            r0 = '0;
            r1 = '0;
         end
      endcase
   end
endmodule

// File: rtl/circ_node_store.sv
module circ_node_store #(
   parameter int DEPTH = 32,
   parameter int VW    = 14,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wa_en,
   input  logic [AW-1:0] wa_addr,
   input  logic [VW-1:0] wa_data,
   input  logic          wb_en,
   input  logic [AW-1:0] wb_addr,
   input  logic [VW-1:0] wb_data,
   input  logic [AW-1:0] rl_addr,
   output logic [VW-1:0] rl_data,
   input  logic [AW-1:0] rr_addr,
   output logic [VW-1:0] rr_data
);
   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("store depth must be a power of two");
      end
   endgenerate

   logic [DEPTH*VW-1:0] flat;

   for (genvar e = 0; e < DEPTH; e++) begin : g_cell
      logic [VW-1:0] q;
      always_ff @(posedge clk) begin
         if (wa_en && wa_addr == AW'(e)) begin
            q <= wa_data;
         end else if (wb_en && wb_addr == AW'(e)) begin
            q <= wb_data;
         end
      end
      assign flat[e*VW +: VW] = q;
   end

   assign rl_data = flat[rl_addr*VW +: VW];
   assign rr_data = flat[rr_addr*VW +: VW];

   // R3: a loaded word fills two different identifiers
   a_r3_two_ids: assert property (@(posedge clk) disable iff (!rst_n)
      wa_en && wb_en |-> wa_addr != wb_addr);
endmodule

// File: rtl/circ_instr_decode.sv
module circ_instr_decode
   import circ_eval_pkg::*;
#(
   parameter int IDW = 5,
   parameter int TW  = 7
) (
   input  logic [MEM_W-1:0] instr,
   input  logic [IDW-1:0]   cur_id,
   input  logic [TW-1:0]    total,
   output op_code_e         op,
   output logic [IDW-1:0]   lid,
   output logic [IDW-1:0]   rid,
   output logic             fault
);
   logic [OPND_W-1:0] lraw, rraw;

   function automatic logic in_range(input logic [OPND_W-1:0] raw,
                                     input logic [IDW-1:0] cur,
                                     input logic [TW-1:0] tot);
      return (raw > OPND_W'(cur)) && (raw < OPND_W'(tot));
   endfunction

   always_comb begin
      lraw  = instr[OPND_W-1:0];
      rraw  = instr[RIGHT_LSB +: OPND_W];
      op    = op_code_e'(instr[CODE_LSB +: 2]);
      lid   = lraw[IDW-1:0];
      rid   = rraw[IDW-1:0];
      fault = (op == OP_RSVD) || !in_range(lraw, cur_id, total)
              || !in_range(rraw, cur_id, total);
   end
endmodule

// File: rtl/arith_circuit_engine.sv
module arith_circuit_engine
   import circ_eval_pkg::*;
#(
   parameter int P         = 97,
   parameter int FW        = 7,
   parameter int NR        = 7,
   parameter int MAX_NODES = 32,
   parameter int ADDR_W    = 16,
   parameter int CTX_W     = 8,
   parameter int TAG_W     = 16,
   localparam int IDW      = $clog2(MAX_NODES),
   localparam int CNT_W    = $clog2(MAX_NODES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CTX_W-1:0]  cmd_ctx,
   input  logic [TAG_W-1:0]  cmd_tag,
   input  logic [ADDR_W-1:0] cmd_ptr,
   input  logic [CNT_W-1:0]  cmd_nread,
   input  logic [CNT_W-1:0]  cmd_neval,
   output logic              busy,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic              rd_word,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [CTX_W-1:0]  rd_ctx,
   output logic [TAG_W-1:0]  rd_tag,
   input  logic [MEM_W-1:0]  rd_data,
   output logic              done,
   output logic              pass,
   output logic              err
);
   localparam int TOT_W = CNT_W + 1;
   localparam int VW    = 2 * FW;

   generate
      if (FW > SLOT_W) begin : g_bad_limb
         $error("limb wider than a word slot");
      end
      if (MAX_NODES < 4) begin : g_bad_nodes
         $error("node store too small");
      end
   endgenerate

   logic              run_q;
   phase_e            phase_q;
   logic [IDW-1:0]    id_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [CTX_W-1:0]  ctx_q;
   logic [TAG_W-1:0]  tag_q;
   logic [CNT_W-1:0]  neval_q;
   logic [TOT_W-1:0]  total_q;
   logic              done_q, pass_q, err_q;

   logic [TOT_W-1:0]  cmd_total;
   logic              cmd_ok, accept, hs, load_last;
   logic [VW-1:0]     slot_lo, slot_hi;
   logic [VW-1:0]     left_v, right_v, res_v;
   logic [IDW-1:0]    lid, rid;
   op_code_e          op;
   logic              fault;
   logic              unused_data;

   assign unused_data = ^rd_data;

   always_comb begin
      cmd_total = TOT_W'(cmd_nread) + TOT_W'(cmd_neval);
      cmd_ok    = (cmd_nread[0] == 1'b0) && (cmd_nread != '0) && (cmd_neval != '0)
                  && (cmd_total <= TOT_W'(MAX_NODES));
      accept    = !run_q && start;
      hs        = run_q && rd_ready;
      load_last = (TOT_W'(id_q) - TOT_W'(2)) == (TOT_W'(neval_q) - TOT_W'(1));
      slot_lo   = {rd_data[SLOT_W +: FW],     rd_data[0 +: FW]};
      slot_hi   = {rd_data[3*SLOT_W +: FW],   rd_data[2*SLOT_W +: FW]};
   end

   circ_instr_decode #(.IDW(IDW), .TW(TOT_W)) u_decode (
      .instr  (rd_data),
      .cur_id (id_q),
      .total  (total_q),
      .op     (op),
      .lid    (lid),
      .rid    (rid),
      .fault  (fault)
   );

   circ_node_store #(.DEPTH(MAX_NODES), .VW(VW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wa_en   (hs && (phase_q == PH_LOAD || !fault)),
      .wa_addr (id_q),
      .wa_data (phase_q == PH_LOAD ? slot_lo : res_v),
      .wb_en   (hs && phase_q == PH_LOAD),
      .wb_addr (id_q - IDW'(1)),
      .wb_data (slot_hi),
      .rl_addr (lid),
      .rl_data (left_v),
      .rr_addr (rid),
      .rr_data (right_v)
   );

   circ_ext_alu #(.P(P), .FW(FW), .NR(NR)) u_alu (
      .op (op),
      .a0 (left_v[FW-1:0]),
      .a1 (left_v[VW-1:FW]),
      .b0 (right_v[FW-1:0]),
      .b1 (right_v[VW-1:FW]),
      .r0 (res_v[FW-1:0]),
      .r1 (res_v[VW-1:FW])
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         phase_q <= PH_LOAD;
         id_q    <= '0;
         ptr_q   <= '0;
         ctx_q   <= '0;
         tag_q   <= '0;
         neval_q <= '0;
         total_q <= '0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            pass_q <= 1'b0;
            if (cmd_ok) begin
               run_q   <= 1'b1;
               phase_q <= PH_LOAD;
               id_q    <= IDW'(cmd_total - TOT_W'(1));
               ptr_q   <= cmd_ptr;
               ctx_q   <= cmd_ctx;
               tag_q   <= cmd_tag;
               neval_q <= cmd_neval;
               total_q <= cmd_total;
               err_q   <= 1'b0;
            end else begin
               done_q <= 1'b1;
               err_q  <= 1'b1;
            end
         end else if (hs) begin
            if (phase_q == PH_LOAD) begin
               ptr_q <= ptr_q + ADDR_W'(4);
               id_q  <= id_q - IDW'(2);
               if (load_last) begin
                  phase_q <= PH_EXEC;
               end
            end else if (fault) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
               err_q  <= 1'b1;
               pass_q <= 1'b0;
            end else if (id_q == '0) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
               pass_q <= (res_v == '0);
               err_q  <= 1'b0;
            end else begin
               id_q  <= id_q - IDW'(1);
               ptr_q <= ptr_q + ADDR_W'(1);
            end
         end
      end
   end

   assign busy     = run_q;
   assign rd_valid = run_q;
   assign rd_word  = (phase_q == PH_LOAD);
   assign rd_addr  = ptr_q;
   assign rd_ctx   = ctx_q;
   assign rd_tag   = tag_q;
   assign done     = done_q;
   assign pass     = pass_q;
   assign err      = err_q;

   a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_word));

   a_r2_ctx_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && $past(rd_valid) |-> $stable(rd_ctx) && $stable(rd_tag));

   a_r3_word_stride: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_ready && rd_word |=> rd_valid && rd_addr == $past(rd_addr) + ADDR_W'(4));

   a_r4_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_ready && !rd_word |=> !(rd_valid && rd_word));

   a_r5_elem_stride: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_ready && !rd_word |=> !rd_valid || rd_addr == $past(rd_addr) + ADDR_W'(1));

   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r8_fault_fails: assert property (@(posedge clk) disable iff (!rst_n)
      done && err |-> !pass);
endmodule

// File: tb/arith_circuit_engine_test.sv
module arith_circuit_engine_test;
   localparam int P     = 97;
   localparam int FW    = 7;
   localparam int NR    = 7;
   localparam int MAXN  = 32;
   localparam int AW    = 16;
   localparam int CW    = $clog2(MAXN + 1);

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [7:0]    cmd_ctx = '0;
   logic [15:0]   cmd_tag = '0;
   logic [AW-1:0] cmd_ptr = '0;
   logic [CW-1:0] cmd_nread = '0;
   logic [CW-1:0] cmd_neval = '0;
   logic          busy, rd_valid, rd_word, done, pass, err;
   logic          rd_ready = 1'b1;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_ctx;
   logic [15:0]   rd_tag;
   logic [63:0]   rd_data;
   logic [63:0]   mem [0:255];

   assign rd_data = mem[rd_addr[7:0]];

   arith_circuit_engine #(.P(P), .FW(FW), .NR(NR), .MAX_NODES(MAXN),
                          .ADDR_W(AW), .CTX_W(8), .TAG_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_ctx(cmd_ctx), .cmd_tag(cmd_tag),
      .cmd_ptr(cmd_ptr), .cmd_nread(cmd_nread), .cmd_neval(cmd_neval), .busy(busy),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_word(rd_word), .rd_addr(rd_addr),
      .rd_ctx(rd_ctx), .rd_tag(rd_tag), .rd_data(rd_data), .done(done), .pass(pass),
      .err(err));

   int n_chk = 0, n_fail = 0;
   int vlo[64], vhi[64], iop[64], il[64], ir[64];
   int nr, ne;
   int e_ptr, e_nr, e_ctx, e_tag, hs_cnt, cyc;
   bit seq_bad, stall_en;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         #2;
         cyc++;
         rd_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
      end
   end

   // handshake monitor: expected request order derived from the command
   always @(negedge clk) begin
      if (rd_valid && rd_ready) begin
         if (hs_cnt < e_nr / 2) begin
            if (!rd_word || int'(rd_addr) != e_ptr + 4 * hs_cnt) seq_bad = 1'b1;
         end else begin
            if (rd_word || int'(rd_addr) != e_ptr + 4 * (e_nr / 2) + (hs_cnt - e_nr / 2))
               seq_bad = 1'b1;
         end
         if (int'(rd_ctx) != e_ctx || int'(rd_tag) != e_tag) seq_bad = 1'b1;
         hs_cnt++;
      end
   end

   task automatic fop(input int op, input int alo, input int ahi, input int blo,
                      input int bhi, output int rlo, output int rhi);
      case (op)
         0: begin rlo = (alo - blo + P) % P; rhi = (ahi - bhi + P) % P; end
         1: begin rlo = (alo * blo + NR * ahi * bhi) % P; rhi = (alo * bhi + ahi * blo) % P; end
         default: begin rlo = (alo + blo) % P; rhi = (ahi + bhi) % P; end
      endcase
   endtask

   task automatic compute_ref(output bit xpass, output bit xerr, output int xhs);
      int total, nlo[64], nhi[64];
      total = nr + ne;
      xpass = 1'b0;
      xerr  = 1'b0;
      xhs   = nr / 2 + ne;
      for (int k = 0; k < nr; k++) begin
         nlo[total - 1 - k] = vlo[k];
         nhi[total - 1 - k] = vhi[k];
      end
      for (int i = 0; i < ne; i++) begin
         int id, rlo, rhi;
         id = ne - 1 - i;
         if (iop[i] == 3 || il[i] <= id || il[i] >= total || ir[i] <= id || ir[i] >= total) begin
            xerr = 1'b1;
            xhs  = nr / 2 + i + 1;
            return;
         end
         fop(iop[i], nlo[il[i]], nhi[il[i]], nlo[ir[i]], nhi[ir[i]], rlo, rhi);
         nlo[id] = rlo;
         nhi[id] = rhi;
         if (id == 0) xpass = (rlo == 0 && rhi == 0);
      end
   endtask

   task automatic load_mem(input int ptr);
      for (int j = 0; j < nr / 2; j++)
         mem[ptr + 4 * j] = 64'(vlo[2*j]) | (64'(vhi[2*j]) << 16)
                          | (64'(vlo[2*j+1]) << 32) | (64'(vhi[2*j+1]) << 48);
      for (int i = 0; i < ne; i++)
         mem[ptr + 4 * (nr / 2) + i] = 64'(il[i]) | (64'(ir[i]) << 30) | (64'(iop[i]) << 60);
   endtask

   task automatic run_eval(input int ptr, input int ctx, input int tag, input bit poke,
                           input string req);
      bit xpass, xerr;
      int xhs, lat;
      compute_ref(xpass, xerr, xhs);
      load_mem(ptr);
      e_ptr = ptr; e_nr = nr; e_ctx = ctx; e_tag = tag;
      hs_cnt = 0; seq_bad = 1'b0;
      @(negedge clk);
      cmd_ptr = AW'(ptr); cmd_ctx = 8'(ctx); cmd_tag = 16'(tag);
      cmd_nread = CW'(nr); cmd_neval = CW'(ne);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 300) begin
         if (poke && lat == 2) begin
            cmd_ptr = AW'(ptr + 64); cmd_ctx = 8'(ctx + 1);
            start = 1'b1;
         end
         @(negedge clk);
         start = 1'b0;
         lat++;
      end
      chk(done == 1'b1, req, "done reached", longint'(done), 1);
      chk(pass == xpass, req, "pass", longint'(pass), longint'(xpass));
      chk(err == xerr, "R7/R8/R9", "err", longint'(err), longint'(xerr));
      chk(hs_cnt == xhs, "R2/R3/R4/R5", "handshake count", hs_cnt, xhs);
      chk(!seq_bad, stall_en ? "R12" : "R2/R3/R4/R5", "request order", longint'(seq_bad), 0);
      if (!stall_en) chk(lat == xhs + 1, "R7", "done latency", lat, xhs + 1);
      @(negedge clk);
      chk(done == 1'b0 && pass == xpass, "R7", "pulse ends, pass held",
          longint'({done, pass}), longint'({1'b0, xpass}));
   endtask

   task automatic run_bad(input int rn, input int en);
      int lat;
      hs_cnt = 0; e_nr = 0;
      @(negedge clk);
      cmd_nread = CW'(rn); cmd_neval = CW'(en); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 50) begin @(negedge clk); lat++; end
      chk(lat == 1 && err && !pass, "R10", "reject timing/flags", lat * 4 + err * 2 + pass, 6);
      repeat (2) @(negedge clk);
      chk(hs_cnt == 0 && !busy, "R10", "no request", hs_cnt, 0);
   endtask

   task automatic set_example(input int s, input int olo, input int ohi);
      int ops[9] = '{0, 1, 0, 0, 1, 1, 2, 1, 2};
      int ls[9]  = '{12, 12, 13, 13, 12, 8, 4, 14, 7};
      int rs[9]  = '{9, 8, 10, 11, 6, 5, 3, 2, 1};
      nr = 6; ne = 9;
      vlo[0] = 5;   vhi[0] = 3;
      vlo[1] = olo; vhi[1] = ohi;
      vlo[2] = s;   vhi[2] = 0;
      vlo[3] = 10;  vhi[3] = 2;
      vlo[4] = 42;  vhi[4] = 0;
      vlo[5] = 1;   vhi[5] = 0;
      for (int i = 0; i < 9; i++) begin iop[i] = ops[i]; il[i] = ls[i]; ir[i] = rs[i]; end
   endtask

   task automatic set_filler();
      nr = 2; ne = 3;
      vlo[0] = 20; vhi[0] = 30; vlo[1] = 4; vhi[1] = 0;
      iop[0] = 0; il[0] = 4; ir[0] = 4;
      iop[1] = 1; il[1] = 2; ir[1] = 2;
      iop[2] = 1; il[2] = 1; ir[2] = 1;
   endtask

   initial begin
      for (int a = 0; a < 256; a++) mem[a] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !rd_valid, "R1", "idle after reset", longint'({busy, rd_valid}), 0);
      chk(!done && !pass && !err, "R1", "flags after reset", longint'({done, pass, err}), 0);

      set_example(1, 42, 0);  run_eval(32, 3, 1000, 0, "R6");
      set_example(1, 41, 0);  run_eval(32, 4, 1001, 0, "R7");
      set_example(0, 10, 2);  run_eval(32, 5, 1002, 0, "R6");
      set_example(0, 11, 2);  run_eval(32, 6, 1003, 0, "R7");
      set_example(1, 42, 0);  run_eval(32, 7, 1004, 1, "R11");
      stall_en = 1'b1;
      set_example(0, 10, 2);  run_eval(32, 8, 1005, 0, "R12");
      stall_en = 1'b0;
      set_filler();           run_eval(64, 9, 77, 0, "R7");

      begin
         int swl[4] = '{0, 1, 96, 13};
         int swh[4] = '{0, 0, 5, 40};
         for (int op = 0; op < 3; op++)
            for (int x = 0; x < 4; x++)
               for (int y = 0; y < 4; y++)
                  for (int w = 0; w < 2; w++) begin
                     int clo, chi;
                     fop(op, swl[x], swh[x], swl[y], swh[y], clo, chi);
                     nr = 4; ne = 2;
                     vlo[0] = swl[x]; vhi[0] = swh[x];
                     vlo[1] = swl[y]; vhi[1] = swh[y];
                     vlo[2] = (clo + w) % P; vhi[2] = chi;
                     vlo[3] = 0; vhi[3] = 0;
                     iop[0] = op; il[0] = 5; ir[0] = 4;
                     iop[1] = 0;  il[1] = 1; ir[1] = 3;
                     run_eval(64, op, x * 4 + y, 0, "R6");
                  end
      end

      set_filler(); iop[0] = 3;  run_eval(64, 1, 5, 0, "R8");
      set_filler(); il[1] = 1;   run_eval(64, 1, 6, 0, "R9");
      set_filler(); ir[0] = 5;   run_eval(64, 1, 7, 0, "R9");
      set_filler(); ir[2] = 0;   run_eval(64, 1, 8, 0, "R9");

      run_bad(3, 2);
      run_bad(0, 2);
      run_bad(4, 0);
      run_bad(30, 4);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule